// File: doc/BRIEF.md
# Two-Source Interrupt Recognition Controller

This block is the interrupt front end of a small 8-bit controller core. It watches two request sources: an external pin, which is active low and shared by several open-drain drivers, and an overflow pulse from the timer. Using strobes from the core's sequencer and decoder, it decides at each instruction boundary whether to force a subroutine call. When it does, it raises a one-cycle call request and presents the 12-bit program address the core must jump to.

The external pin is level sensitive. It is sampled once per machine cycle on the address latch strobe, except during the first cycle of a two-cycle instruction. Each source has its own enable bit, which the core sets and clears with decoded instruction strobes. A single in-progress bit is set when the core executes the interrupt call and cleared when it executes return-and-restore. While that bit is set, both sources are locked out whatever their enables say. The timer flag records every overflow. The overflow latch that can raise a timer interrupt records an overflow only while timer interrupts are enabled.

The block has no data stream, so every pin is a plain control or status signal with no handshake. The core must treat the call request as committed on the cycle it is seen.

Top module: `irq_recognizer`

## Requirements
- R1: On a rising clock edge with `ale`=1 and `first_of_two`=0, the external sample takes the inverse of `ext_req_n`, so a low pin means pending. The sample holds its value between such edges. A pin that returns high before the next sample withdraws the request.
- R2: When `first_of_two`=1, an `ale` edge takes no sample and the previous sample is kept.
- R3: `call_req` is combinational and can be 1 only in a cycle where `last_cyc`=1. While `call_req`=1, `call_vec` is 3 for an external call or 7 for a timer call. While `call_req`=0, `call_vec` is 0.
- R4: When both sources are enabled and pending at the same boundary, the external source is served (vector 3). The timer stays pending and is served at a later boundary.
- R5: The external and timer enable bits are cleared by reset, set by their enable strobe and cleared by their disable strobe. If both strobes arrive in the same cycle, the disable wins. A disabled source never raises `call_req`.
- R6: `call_exec` sets `in_prog` on the next edge. `retr_exec` or reset clears it, and `retr_exec` wins when both arrive together. While `in_prog`=1, `call_req` stays 0 regardless of either enable.
- R7: After `call_req` has been issued, no further request is issued until `call_exec` arrives.
- R8: `tmr_flag` is set by `tmr_ovf` whether or not timer interrupts are enabled. It is cleared by `jtf_exec`, and a set wins over a clear in the same cycle. Reset clears it.
- R9: An overflow that arrives while timer interrupts are disabled is never stored for interrupt purposes, so enabling the timer afterwards raises no request. When the core executes the call for a timer request, the stored overflow is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_req_n | input | 1 | External request pin, active low, level sensitive |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ale | input | 1 | Address latch strobe, one per machine cycle |
| last_cyc | input | 1 | Last cycle of the current instruction |
| first_of_two | input | 1 | First cycle of a two-cycle instruction |
| ext_en_exec | input | 1 | Enable-external instruction executed |
| ext_dis_exec | input | 1 | Disable-external instruction executed |
| tmr_en_exec | input | 1 | Enable-timer instruction executed |
| tmr_dis_exec | input | 1 | Disable-timer instruction executed |
| retr_exec | input | 1 | Return-and-restore executed |
| call_exec | input | 1 | Interrupt call executed |
| jtf_exec | input | 1 | Jump-on-timer-flag executed |
| call_req | output | 1 | One-cycle request to force a call |
| call_vec | output | 12 | Call target address |
| in_prog | output | 1 | Interrupt service in progress |
| tmr_flag | output | 1 | Timer flag |

## Verification
The bench sweeps all sixteen combinations of the two enables and the two pending conditions. For each one it checks the request and vector at the boundary, the lockout after the call executes, and what remains pending after the return. A design with the wrong priority would vector to 7 when both sources are pending. A design that cleared the overflow latch on the wrong call would either lose the deferred timer request or repeat a timer call. Directed cases cover an `ale` edge during the first half of a two-cycle instruction, where a faulty sampler would catch the pin early. They also cover an overflow taken while the timer is disabled, which a faulty latch would turn into a spurious call once the timer is enabled. Further cases exercise simultaneous set and clear strobes, where the wrong priority flips the enable bit or the flag.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_TMR  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_ext_sampler.sv
module irq_ext_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic ale,
  input  logic first_of_two,
  output logic seen
);
  logic take;
  assign take = ale & ~first_of_two;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen <= 1'b0;
    else if (take) seen <= ~req_n;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_en_exec,
  input  logic ext_dis_exec,
  input  logic tmr_en_exec,
  input  logic tmr_dis_exec,
  input  logic call_exec,
  input  logic retr_exec,
  output logic ext_en_q,
  output logic tmr_en_q,
  output logic in_prog_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_en_q  <= 1'b0;
      tmr_en_q  <= 1'b0;
      in_prog_q <= 1'b0;
    end else begin
      if (ext_dis_exec)      ext_en_q <= 1'b0;
      else if (ext_en_exec)  ext_en_q <= 1'b1;
      if (tmr_dis_exec)      tmr_en_q <= 1'b0;
      else if (tmr_en_exec)  tmr_en_q <= 1'b1;
      if (retr_exec)         in_prog_q <= 1'b0;
      else if (call_exec)    in_prog_q <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_timer_track.sv
module irq_timer_track (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_ovf,
  input  logic tmr_en,
  input  logic jtf_exec,
  input  logic tmr_served,
  output logic flag_q,
  output logic ovf_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (tmr_ovf)        flag_q <= 1'b1;
      else if (jtf_exec)  flag_q <= 1'b0;
      if (tmr_ovf && tmr_en) ovf_q <= 1'b1;
      else if (tmr_served)   ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     last_cyc,
  input  logic     ext_go,
  input  logic     tmr_go,
  input  logic     in_prog,
  input  logic     call_exec,
  output logic     req,
  output irq_src_e src,
  output logic     tmr_served,
  output logic     pend_q
);
  irq_src_e pend_src_q;
  logic     blocked;

  assign blocked = in_prog | pend_q;
  assign req     = last_cyc & ~blocked & (ext_go | tmr_go);

  always_comb begin
    if (!req)        src = SRC_NONE;
    else if (ext_go) src = SRC_EXT;
    else             src = SRC_TMR;
  end

  assign tmr_served = call_exec & pend_q & (pend_src_q == SRC_TMR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_src_q <= SRC_NONE;
    end else if (req) begin
      pend_q     <= 1'b1;
      pend_src_q <= src;
    end else if (call_exec) begin
      pend_q     <= 1'b0;
      pend_src_q <= SRC_NONE;
    end
  end
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
  import irq_pkg::*;
#(
  parameter int VEC_W   = 12,
  parameter int EXT_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_req_n,
  input  logic             tmr_ovf,
  input  logic             ale,
  input  logic             last_cyc,
  input  logic             first_of_two,
  input  logic             ext_en_exec,
  input  logic             ext_dis_exec,
  input  logic             tmr_en_exec,
  input  logic             tmr_dis_exec,
  input  logic             retr_exec,
  input  logic             call_exec,
  input  logic             jtf_exec,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec,
  output logic             in_prog,
  output logic             tmr_flag
);
  localparam logic [VEC_W-1:0] EXT_ADDR = VEC_W'(EXT_VEC);
  localparam logic [VEC_W-1:0] TMR_ADDR = VEC_W'(TMR_VEC);

  logic     ext_seen, ext_en_q, tmr_en_q, ovf_q, tmr_served, pend_q;
  irq_src_e src;

  irq_ext_sampler u_samp (
    .clk, .rst_n, .req_n(ext_req_n), .ale, .first_of_two, .seen(ext_seen)
  );

  irq_ctrl_regs u_regs (
    .clk, .rst_n, .ext_en_exec, .ext_dis_exec, .tmr_en_exec, .tmr_dis_exec,
    .call_exec, .retr_exec, .ext_en_q, .tmr_en_q, .in_prog_q(in_prog)
  );

  irq_timer_track u_tmr (
    .clk, .rst_n, .tmr_ovf, .tmr_en(tmr_en_q), .jtf_exec, .tmr_served,
    .flag_q(tmr_flag), .ovf_q
  );

  irq_arbiter u_arb (
    .clk, .rst_n, .last_cyc,
    .ext_go(ext_en_q & ext_seen), .tmr_go(tmr_en_q & ovf_q),
    .in_prog, .call_exec, .req(call_req), .src, .tmr_served, .pend_q
  );

  always_comb begin
    case (src)
      SRC_EXT: call_vec = EXT_ADDR;
      SRC_TMR: call_vec = TMR_ADDR;
      default: call_vec = '0;
    endcase
  end
endmodule

// File: rtl/irq_recognizer_chk.sv
module irq_recognizer_chk #(
  parameter int VEC_W   = 12,
  parameter int EXT_VEC = 3,
  parameter int TMR_VEC = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             last_cyc,
  input logic             tmr_ovf,
  input logic             call_exec,
  input logic             retr_exec,
  input logic             call_req,
  input logic [VEC_W-1:0] call_vec,
  input logic             in_prog,
  input logic             tmr_flag,
  input logic             ext_en_q,
  input logic             tmr_en_q,
  input logic             ext_seen,
  input logic             ovf_q
);
  // R3
  a_r3_req_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> last_cyc);
  // R3
  a_r3_idle_vec: assert property (@(posedge clk) disable iff (!rst_n)
    !call_req |-> call_vec == '0);
  // R4
  a_r4_ext_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && ext_en_q && ext_seen) |-> call_vec == VEC_W'(EXT_VEC));
  // R5
  a_r5_tmr_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && call_vec == VEC_W'(TMR_VEC)) |-> tmr_en_q);
  // R6
  a_r6_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    in_prog |-> !call_req);
  // R6
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (call_exec && !retr_exec) |=> in_prog);
  // R6
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    retr_exec |=> !in_prog);
  // R7
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);
  // R8
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_flag);
  // R9
  a_r9_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_ovf && !tmr_en_q && !ovf_q) |=> !ovf_q);
endmodule

bind irq_recognizer irq_recognizer_chk #(
  .VEC_W(VEC_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)
) u_chk (
  .clk, .rst_n, .last_cyc, .tmr_ovf, .call_exec, .retr_exec,
  .call_req, .call_vec, .in_prog, .tmr_flag,
  .ext_en_q, .tmr_en_q, .ext_seen, .ovf_q
);

// File: tb/sim_irq_recognizer.sv
`timescale 1ns/1ps
module sim_irq_recognizer;
  logic clk = 1'b0;
  logic rst_n;
  logic ext_req_n, tmr_ovf, ale, last_cyc, first_of_two;
  logic ext_en_exec, ext_dis_exec, tmr_en_exec, tmr_dis_exec;
  logic retr_exec, call_exec, jtf_exec;
  logic call_req, in_prog, tmr_flag;
  logic [11:0] call_vec;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  irq_recognizer u0 (.*);

  task automatic clear_strobes();
    tmr_ovf = 0; ale = 0; last_cyc = 0; first_of_two = 0;
    ext_en_exec = 0; ext_dis_exec = 0; tmr_en_exec = 0; tmr_dis_exec = 0;
    retr_exec = 0; call_exec = 0; jtf_exec = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clear_strobes();
    #0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    clear_strobes(); ext_req_n = 1; rst_n = 0;
    step(); step();
    rst_n = 1; step();
  endtask

  task automatic boundary(input string req, input int exp_req, input int exp_vec);
    last_cyc = 1; #1;
    chk({req, " call_req"}, call_req, exp_req);
    chk({req, " call_vec"}, call_vec, exp_vec);
    step();
  endtask

  task automatic sample_pin(input logic level);
    ext_req_n = level; ale = 1; step();
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // reset state
    chk("R6 reset in_prog", in_prog, 0);
    chk("R8 reset tmr_flag", tmr_flag, 0);
    chk("R3 reset call_req", call_req, 0);

    // sweep: ext enable, timer enable, ext pending, overflow
    for (int k = 0; k < 16; k++) begin
      bit e, t, x, o;
      int er, ev, ext_won;
      e = k[0]; t = k[1]; x = k[2]; o = k[3];
      do_reset();
      if (e) begin ext_en_exec = 1; step(); end
      if (t) begin tmr_en_exec = 1; step(); end
      if (x) sample_pin(0);
      if (o) begin tmr_ovf = 1; step(); end
      chk("R8 flag follows overflow", tmr_flag, o);
      er = (e && x) || (t && o);
      ev = (e && x) ? 3 : ((t && o) ? 7 : 0);
      ext_won = e && x;
      boundary("R4 sweep", er, ev);
      if (er) begin
        call_exec = 1; step();
        chk("R6 in_prog after call", in_prog, 1);
        boundary("R6 lockout", 0, 0);
        retr_exec = 1; step();
        chk("R6 in_prog after return", in_prog, 0);
        sample_pin(1);  // R1 pin released withdraws external request
        if (ext_won && t && o) boundary("R9 deferred timer", 1, 7);
        else boundary("R9 nothing left", 0, 0);
      end
    end

    // R1 release before sample withdraws request
    do_reset();
    ext_en_exec = 1; step();
    sample_pin(0); sample_pin(1);
    boundary("R1 released", 0, 0);
    // R3 no request without last_cyc
    sample_pin(0); #1;
    chk("R3 no last_cyc call_req", call_req, 0);
    chk("R3 no last_cyc call_vec", call_vec, 0);
    // R7 no repeat before call executes
    boundary("R7 first", 1, 3);
    boundary("R7 repeat blocked", 0, 0);
    call_exec = 1; step(); retr_exec = 1; step();
    boundary("R7 after service", 1, 3);

    // R2 sampling skipped on first of two
    do_reset();
    ext_en_exec = 1; step();
    ext_req_n = 0; ale = 1; first_of_two = 1; step();
    boundary("R2 skipped sample", 0, 0);
    ale = 1; step();
    boundary("R2 normal sample", 1, 3);

    // R5 disable wins; disabled source silent
    do_reset();
    ext_en_exec = 1; ext_dis_exec = 1; step();
    sample_pin(0);
    boundary("R5 disable wins", 0, 0);
    ext_en_exec = 1; step(); ext_dis_exec = 1; step();
    boundary("R5 disabled after enable", 0, 0);
    tmr_en_exec = 1; tmr_dis_exec = 1; step();
    tmr_ovf = 1; step();
    tmr_en_exec = 1; step();
    // R9 overflow while disabled not stored
    boundary("R9 disabled overflow lost", 0, 0);
    chk("R8 flag set while disabled", tmr_flag, 1);
    jtf_exec = 1; step();
    chk("R8 jtf clears flag", tmr_flag, 0);
    tmr_ovf = 1; jtf_exec = 1; step();
    chk("R8 set beats clear", tmr_flag, 1);
    // timer now enabled; that overflow was stored
    boundary("R9 enabled overflow", 1, 7);
    call_exec = 1; retr_exec = 1; step();
    chk("R6 return wins", in_prog, 0);
    boundary("R9 cleared by timer call", 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule